// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table in memory. A caller hands over one request at a time: the address, the kind of access (load, store or instruction fetch), the effective privilege, the root page number and the paging-enable bit of the translation register, and two status bits. One status bit lets supervisor code touch user pages. The other lets loads read pages that are only executable. The walker reads one 32-bit table entry per level through a single memory port. It checks the leaf it finds, and returns a physical address with read/write/execute permissions, or a fault.

If the leaf is legal but its accessed flag is clear, or a store meets a clean page, the walker writes the updated entry back to the same table address before it answers. A leaf found at the upper level maps a 4 MiB superpage. For such a leaf the lower ten bits of the virtual page number replace the low page-number bits. The block is meant to sit behind a translation cache and to be started only on a miss.

Top module: `ptw_sv32`

## Requirements
- R1: When paging is off (`req_paged`=0) or the privilege is machine (`req_priv`=3), the response comes one cycle after acceptance. It carries the virtual address zero-extended to 34 bits, R=W=X=1 and no fault, and the walker makes no memory access.
- R2: The first table read goes to root page number × 4096 + vaddr[31:22] × 4. A pointer entry makes the second read go to its page number × 4096 + vaddr[21:12] × 4. An entry holds the page number in bits 31:10, then D, A, G, U, X, W, R and V in bits 7 down to 0.
- R3: An entry with V=0 faults, and so does a read response flagged with an error.
- R4: A leaf whose R/W/X flags are W alone, or W with X, faults.
- R5: The privilege codes are 0 (user) and 1 (supervisor). A leaf with U=1 faults at supervisor level when the user-page permit is 0 or the access is a fetch. A leaf with U=0 faults at user level.
- R6: An upper-level leaf whose page number has any of its low ten bits set faults.
- R7: The access codes are 0 (load), 1 (store) and 2 (fetch). A load needs R, or needs X with the readable-executable bit set. A store needs W. A fetch needs X. A missing permission faults.
- R8: On success the entry is written back with A set, and with D also set on a store. The write happens only if this changes the entry. A faulting walk never writes.
- R9: A 4 KiB leaf gives {page number, vaddr[11:0]}. A superpage gives {page number[21:10], vaddr[21:12], vaddr[11:0]}.
- R10: The reported R is R or (X and readable-executable). The reported X is X. The reported W is W and (store or D already set).
- R11: A pointer entry at the lower level faults.
- R12: Each accepted request produces exactly one one-cycle `rsp_valid` pulse. `req_ready` is low while a walk is in progress. A fault reports a zero address and no permissions. A pending memory request holds its address and data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| req_paged | input | 1 | Paging enabled in translation register |
| req_root_pn | input | 22 | Root table page number |
| req_user_ok | input | 1 | Supervisor may access user pages |
| req_exec_rd | input | 1 | Loads may read execute-only pages |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permitted |
| rsp_w | output | 1 | Write permitted |
| rsp_x | output | 1 | Execute permitted |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write of the updated entry, 0 read |
| mem_req_addr | output | 34 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read |
| mem_rsp_err | input | 1 | Read failed |

## Verification
Two functions meet in the single cycle where a leaf arrives. The leaf check decides legality and reported permissions from the entry as read, while the update logic forms the rewritten entry with A and D set. A store to a clean, never-accessed page provokes both at once. The bench then judges that the write data carries the new flags, yet the reported write permission follows the store rule and not the value just written. A read error that arrives on an otherwise legal entry is the second pairing. It must win over the leaf path, so the walk faults and no write follows.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  // entry flag positions
  localparam int F_V = 0;
  localparam int F_R = 1;
  localparam int F_W = 2;
  localparam int F_X = 3;
  localparam int F_U = 4;
  localparam int F_A = 6;
  localparam int F_D = 7;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WR    = 3'd3,
    ST_DONE  = 3'd4
  } walk_st_e;
endpackage

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       kind,
  input  logic [1:0]       priv,
  input  logic             user_ok,
  input  logic             exec_rd,
  input  logic             misal,
  output logic             fault,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic [PTE_W-1:0] new_pte,
  output logic             need_wr
);
  logic v, r, w, x, u, d;
  logic rsvd, priv_bad, acc_ok;

  always_comb begin
    v = pte[F_V];
    r = pte[F_R];
    w = pte[F_W];
    x = pte[F_X];
    u = pte[F_U];
    d = pte[F_D];
    // write-only and write+execute are both "W without R"
    rsvd = w && !r;
    if (u) priv_bad = (priv != PRIV_U) && (!user_ok || kind == ACC_FETCH);
    else   priv_bad = (priv != PRIV_S);
    case (kind)
      ACC_LOAD:  acc_ok = r || (x && exec_rd);
      ACC_STORE: acc_ok = w;
      ACC_FETCH: acc_ok = x;
      default:   acc_ok = 1'b0;
    endcase
    fault   = !v || !(r || w || x) || rsvd || priv_bad || misal || !acc_ok;
    new_pte = pte;
    new_pte[F_A] = 1'b1;
    if (kind == ACC_STORE) new_pte[F_D] = 1'b1;
    need_wr = (new_pte != pte);
    perm_r  = r || (x && exec_rd);
    perm_x  = x;
    perm_w  = w && (kind == ACC_STORE || d);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 34,
  parameter int PG_SHIFT  = 12,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 2,
  parameter int PTE_BYTES = 4,
  localparam int PPN_W    = PA_W - PG_SHIFT,
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] base_pn,
  input  logic [PPN_W-1:0] leaf_pn,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  leaf_pa,
  output logic             misal
);
  localparam int ESZ_SH = $clog2(PTE_BYTES);

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [PPN_W-1:0] pn_arr  [LEVELS];
  logic             mis_arr [LEVELS];
  logic [PPN_W-1:0] vpn_ext;
  logic [IDX_W-1:0] idx_sel;
  logic [PPN_W-1:0] pn_sel;

  assign vpn_ext = PPN_W'(va[VA_W-1:PG_SHIFT]);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam logic [PPN_W-1:0] LOW = (PPN_W'(1) << (g * IDX_W)) - PPN_W'(1);
    assign idx_arr[g] = va[PG_SHIFT + g*IDX_W +: IDX_W];
    assign pn_arr[g]  = (leaf_pn & ~LOW) | (vpn_ext & LOW);
    assign mis_arr[g] = |(leaf_pn & LOW);
  end

  always_comb begin
    idx_sel = '0;
    pn_sel  = leaf_pn;
    misal   = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) begin
        idx_sel = idx_arr[i];
        pn_sel  = pn_arr[i];
        misal   = mis_arr[i];
      end
    end
  end

  assign pte_addr = (PA_W'(base_pn) << PG_SHIFT) + (PA_W'(idx_sel) << ESZ_SH);
  assign leaf_pa  = {pn_sel, va[PG_SHIFT-1:0]};
endmodule

// File: rtl/ptw_sv32.sv
module ptw_sv32
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 34,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 10,
  parameter int LEVELS   = 2,
  parameter int PTE_W    = 32,
  localparam int PPN_W   = PA_W - PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_priv,
  input  logic             req_paged,
  input  logic [PPN_W-1:0] req_root_pn,
  input  logic             req_user_ok,
  input  logic             req_exec_rd,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_r,
  output logic             rsp_w,
  output logic             rsp_x,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  input  logic             mem_rsp_err
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int FLG_W = PTE_W - PPN_W;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q, priv_q;
  logic             uok_q, xrd_q;
  logic [PPN_W-1:0] base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] wdata_q;
  logic             flt_q, r_q, w_q, x_q;
  logic [PA_W-1:0]  pa_q;

  logic [PPN_W-1:0] ent_pn;
  logic             ent_v, ent_ptr;
  logic [PA_W-1:0]  pte_addr, leaf_pa;
  logic             misal;
  logic             lc_fault, lc_r, lc_w, lc_x, lc_need_wr;
  logic [PTE_W-1:0] lc_new;
  logic             bypass, walk_fail;

  assign ent_pn  = mem_rsp_data[PTE_W-1:FLG_W];
  assign ent_v   = mem_rsp_data[F_V];
  assign ent_ptr = ent_v && !(mem_rsp_data[F_R] || mem_rsp_data[F_W] || mem_rsp_data[F_X]);

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .PTE_BYTES(PTE_W/8)
  ) u_addr (
    .va(va_q), .lvl(lvl_q), .base_pn(base_q), .leaf_pn(ent_pn),
    .pte_addr(pte_addr), .leaf_pa(leaf_pa), .misal(misal)
  );

  ptw_leaf_check #(.PTE_W(PTE_W)) u_leaf (
    .pte(mem_rsp_data), .kind(kind_q), .priv(priv_q),
    .user_ok(uok_q), .exec_rd(xrd_q), .misal(misal),
    .fault(lc_fault), .perm_r(lc_r), .perm_w(lc_w), .perm_x(lc_x),
    .new_pte(lc_new), .need_wr(lc_need_wr)
  );

  assign bypass = !req_paged || (req_priv == PRIV_M);

  // error wins over any entry content
  assign walk_fail = mem_rsp_err || !ent_v ||
                     (ent_ptr && lvl_q == '0) ||
                     (!ent_ptr && lc_fault);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      kind_q  <= '0;
      priv_q  <= '0;
      uok_q   <= 1'b0;
      xrd_q   <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      wdata_q <= '0;
      flt_q   <= 1'b0;
      r_q     <= 1'b0;
      w_q     <= 1'b0;
      x_q     <= 1'b0;
      pa_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            kind_q <= req_kind;
            priv_q <= req_priv;
            uok_q  <= req_user_ok;
            xrd_q  <= req_exec_rd;
            base_q <= req_root_pn;
            lvl_q  <= TOP_LVL;
            if (bypass) begin
              pa_q  <= PA_W'(req_vaddr);
              r_q   <= 1'b1;
              w_q   <= 1'b1;
              x_q   <= 1'b1;
              flt_q <= 1'b0;
              st_q  <= ST_DONE;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (mem_req_ready) st_q <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rsp_valid) begin
            if (walk_fail) begin
              flt_q <= 1'b1;
              pa_q  <= '0;
              r_q   <= 1'b0;
              w_q   <= 1'b0;
              x_q   <= 1'b0;
              st_q  <= ST_DONE;
            end else if (ent_ptr) begin
              base_q <= ent_pn;
              lvl_q  <= lvl_q - 1'b1;
              st_q   <= ST_RD;
            end else begin
              flt_q   <= 1'b0;
              pa_q    <= leaf_pa;
              r_q     <= lc_r;
              w_q     <= lc_w;
              x_q     <= lc_x;
              wdata_q <= lc_new;
              st_q    <= lc_need_wr ? ST_WR : ST_DONE;
            end
          end
        end
        ST_WR: begin
          if (mem_req_ready) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_fault     = flt_q;
  assign rsp_paddr     = pa_q;
  assign rsp_r         = r_q;
  assign rsp_w         = w_q;
  assign rsp_x         = x_q;
  assign mem_req_valid = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_req_we    = (st_q == ST_WR);
  assign mem_req_addr  = pte_addr;
  assign mem_req_wdata = wdata_q;
endmodule

// File: rtl/ptw_sv32_chk.sv
module ptw_sv32_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 34,
  parameter int IDX_W = 10,
  parameter int PTE_W = 32,
  localparam int PPN_W = PA_W - 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [1:0]       req_priv,
  input logic             req_paged,
  input logic [PPN_W-1:0] req_root_pn,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic             rsp_r,
  input logic             rsp_w,
  input logic             rsp_x,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_err
);
  a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (!req_paged || req_priv == 2'b11))
      |=> (rsp_valid && !rsp_fault && rsp_r && rsp_w && rsp_x && !mem_req_valid));

  a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_paged && req_priv != 2'b11)
      |=> (mem_req_valid && !mem_req_we &&
           mem_req_addr == {$past(req_root_pn), $past(req_vaddr[VA_W-1 -: IDX_W]), 2'b00}));

  a_r3_err_faults: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_err) |=> (rsp_valid && rsp_fault));

  a_r8_wr_sets_a: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[6]);

  a_r8_wr_then_ok: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we && mem_req_ready) |=> (rsp_valid && !rsp_fault));

  a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r12_fault_noperm: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !(rsp_r || rsp_w || rsp_x));

  a_r12_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || rsp_valid) |-> !req_ready);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
endmodule

bind ptw_sv32 ptw_sv32_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .PTE_W(PTE_W)
) u_chk (.*);

// File: tb/sim_ptw_sv32.sv
module sim_ptw_sv32;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind, req_priv;
  logic        req_paged, req_user_ok, req_exec_rd;
  logic [21:0] req_root_pn;
  logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [33:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;

  always #10 clk = ~clk;

  ptw_sv32 u0 (.*);

  // memory model: table words driven by the stimulus, accesses logged here
  logic [31:0] mem [0:1023];
  logic [31:0] cyc, rd_cnt, wr_cnt, wr_data;
  logic [33:0] wr_addr;
  logic [33:0] rd_log [0:3];
  logic        inj_err;

  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0; rd_cnt <= 0; wr_cnt <= 0; wr_data <= 0; wr_addr <= 0;
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_err <= 1'b0; mem_rsp_data <= 0;
    end else begin
      cyc <= cyc + 1;
      mem_req_ready <= (cyc[2:0] != 3'd5);
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          wr_cnt <= wr_cnt + 1; wr_addr <= mem_req_addr; wr_data <= mem_req_wdata;
        end else begin
          rd_log[rd_cnt[1:0]] <= mem_req_addr;
          rd_cnt <= rd_cnt + 1;
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[11:2]];
          mem_rsp_err   <= inj_err;
        end
      end
    end
  end

  int total = 0, fails = 0;
  bit hung = 0;
  logic [31:0] rd0, wr0, nrd, nwr;
  logic        g_f, g_r, g_w, g_x;
  logic [33:0] g_pa;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                      input logic paged, input logic [21:0] root, input logic uok, input logic xrd);
    int t;
    if (hung) return;
    @(negedge clk);
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_vaddr = va; req_kind = kind; req_priv = priv; req_paged = paged;
    req_root_pn = root; req_user_ok = uok; req_exec_rd = xrd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    if (!rsp_valid) begin
      hung = 1;
      check(1'b0, "R12", "watchdog: no response", 0, 1);
    end
    g_f = rsp_fault; g_r = rsp_r; g_w = rsp_w; g_x = rsp_x; g_pa = rsp_paddr;
    nrd = rd_cnt - rd0; nwr = wr_cnt - wr0;
  endtask

  localparam logic [31:0] VA    = {10'd3, 10'd5, 12'h234};
  localparam logic [21:0] PN4K  = 22'h2ABCD;
  localparam logic [21:0] PNSP  = 22'h155C00;

  logic [7:0]  fl;
  logic [21:0] pn;
  logic [31:0] pte, e_data;
  logic        r, w, x, u, a, d, ef, ewr, er, ew, ex;
  logic [33:0] epa;
  logic [1:0]  erd;
  string       tag;

  initial begin
    rst = 1'b1; req_valid = 1'b0; inj_err = 1'b0;
    req_vaddr = 0; req_kind = 0; req_priv = 0; req_paged = 0;
    req_root_pn = 0; req_user_ok = 0; req_exec_rd = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R12", "reset state",
          {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    // R1: bypass with paging off, and with machine privilege
    walk(32'hDEAD_BEEF, 2'd0, 2'd0, 1'b0, 22'd1, 1'b0, 1'b0);
    check(!g_f && g_pa == 34'h0DEADBEEF && g_r && g_w && g_x && nrd == 0, "R1", "paging off",
          {g_f, g_r, g_w, g_x, nrd[3:0], g_pa}, {4'b0111, 4'd0, 34'h0DEADBEEF});
    walk(32'h8000_0FFC, 2'd1, 2'd3, 1'b1, 22'd1, 1'b0, 1'b0);
    check(!g_f && g_pa == 34'h080000FFC && g_r && g_w && g_x && nrd == 0, "R1", "machine level",
          {g_f, g_r, g_w, g_x, nrd[3:0], g_pa}, {4'b0111, 4'd0, 34'h080000FFC});

    // R2: table addresses at both levels, clean legal load
    mem[10'h3FF] = {22'h3, 10'h001};
    mem[10'h001] = {22'h0ABCD, 10'h0C7};
    walk({10'h3FF, 10'h001, 12'h0AC}, 2'd0, 2'd1, 1'b1, 22'h2A5, 1'b0, 1'b0);
    check(nrd == 2 && rd_log[rd0[1:0]] == 34'h2A5FFC && rd_log[rd0[1:0] + 2'd1] == 34'h3004,
          "R2", "entry addresses", {rd_log[rd0[1:0]][31:0], rd_log[rd0[1:0] + 2'd1][31:0]},
          {32'h2A5FFC, 32'h3004});
    check(!g_f && g_pa == {22'h0ABCD, 12'h0AC} && g_r && g_w && !g_x && nwr == 0, "R9", "4K leaf result",
          {g_f, g_r, g_w, g_x, nwr[3:0], g_pa}, {4'b0110, 4'd0, 22'h0ABCD, 12'h0AC});
    @(negedge clk);
    check(!rsp_valid && req_ready, "R12", "single pulse", {rsp_valid, req_ready}, 2'b01);

    // R3: read error on a legal path
    inj_err = 1'b1;
    walk({10'h3FF, 10'h001, 12'h0AC}, 2'd0, 2'd1, 1'b1, 22'h2A5, 1'b0, 1'b0);
    inj_err = 1'b0;
    check(g_f && nrd == 1 && nwr == 0 && !g_r && !g_w && !g_x && g_pa == 0, "R3", "read error",
          {g_f, nrd[3:0], nwr[3:0]}, {1'b1, 4'd1, 4'd0});

    // R11: pointer at the lower level
    mem[10'h001] = {22'h5, 10'h001};
    walk({10'h3FF, 10'h001, 12'h0AC}, 2'd0, 2'd1, 1'b1, 22'h2A5, 1'b0, 1'b0);
    check(g_f && nrd == 2 && nwr == 0, "R11", "pointer at last level",
          {g_f, nrd[3:0], nwr[3:0]}, {1'b1, 4'd2, 4'd0});

    // sweep: leaf flags x access x privilege x status bits x leaf shape
    for (int f = 0; f < 128; f++)
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 2; s++)
            for (int m = 0; m < 2; m++)
              for (int lv = 0; lv < 3; lv++) begin
                fl = {f[6:5], 1'b0, f[4:0]};
                if (!(lv != 0 && fl[0] && fl[3:1] == 3'b000) && !hung) begin
                  pn  = (lv == 0) ? PN4K : ((lv == 1) ? PNSP : (PNSP | 22'd1));
                  pte = {pn, 2'b00, fl};
                  if (lv == 0) begin mem[10'd3] = {22'd2, 10'h001}; mem[10'd5] = pte; end
                  else mem[10'd3] = pte;
                  walk(VA, k[1:0], p[1:0], 1'b1, 22'd1, s[0], m[0]);
                  r = fl[1]; w = fl[2]; x = fl[3]; u = fl[4]; a = fl[6]; d = fl[7];
                  tag = "R8/R9/R10";
                  if (!fl[0]) tag = "R3";
                  else if (!(r || w || x)) tag = "R11";
                  else if (w && !r) tag = "R4";
                  else if (u ? (p != 0 && (!s[0] || k == 2)) : (p != 1)) tag = "R5";
                  else if (lv == 2) tag = "R6";
                  else if (!((k == 0) ? (r || (x && m[0])) : (k == 1) ? w : x)) tag = "R7";
                  ef  = (tag != "R8/R9/R10");
                  ewr = !ef && (!a || (k == 1 && !d));
                  e_data = pte | 32'h40 | ((k == 1) ? 32'h80 : 32'h0);
                  er = !ef && (r || (x && m[0]));
                  ex = !ef && x;
                  ew = !ef && w && (k == 1 || d);
                  epa = ef ? 34'h0 : ((lv == 0) ? {PN4K, 12'h234} : {PNSP[21:10], 10'd5, 12'h234});
                  erd = (lv == 0) ? 2'd2 : 2'd1;
                  check({g_f, g_r, g_w, g_x, g_pa, nwr[1:0], nrd[1:0]} ==
                        {ef, er, ew, ex, epa, 1'(ewr) ? 2'd1 : 2'd0, erd},
                        tag, $sformatf("flags=%h kind=%0d priv=%0d uok=%0d xrd=%0d shape=%0d", fl, k, p, s, m, lv),
                        {g_f, g_r, g_w, g_x, g_pa, nwr[1:0], nrd[1:0]},
                        {ef, er, ew, ex, epa, 1'(ewr) ? 2'd1 : 2'd0, erd});
                  if (ewr)
                    check(wr_data == e_data && wr_addr == ((lv == 0) ? 34'h2014 : 34'h100C), "R8",
                          "written entry", {wr_addr[31:0], wr_data},
                          {((lv == 0) ? 32'h2014 : 32'h100C), e_data});
                end
              end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++; total++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule